// File: doc/BRIEF.md
# Opcode-Programmed Half-Duplex SPI Master

This block is an SPI master whose bus activity is described by a short program instead of being kicked off by a data write. The host loads a 64-bit program word holding eight one-byte instructions. The sequencer steps through them from the top byte down. It can select a device, send bytes taken from a 64-bit transmit holding register, collect bytes into a 64-bit receive holding register, branch back to an earlier slot while a loop counter is nonzero, and halt. The host keeps the transmit register fed and the receive register drained, and paces itself with the full flags in the status word. The sequencer stalls with SCK idle whenever data it needs is missing, or when there is no room for data it would produce.

The host side is a simple single-cycle register port. Writes take effect on the clock edge. Read data is combinational from the address. A read strobe on the receive address counts as the host having read that register. Six addresses are decoded:
- 0 program
- 1 loop count, held in bits 39:32
- 2 clock/reset, with the divider in bits 63:52
- 3 transmit data
- 4 receive data
- 5 status

The SPI side runs mode 0, most significant bit first. SCK is the system clock divided by 2×(divider+1).

Sequencer states are Idle, Decode, WaitTx, WaitRx and Shift:
- Idle→Decode happens on a program write.
- Decode→Decode happens on a select, or on a branch, whether taken or not.
- Decode→WaitTx and Decode→WaitRx happen on shift opcodes.
- Decode→Idle happens on a stop, an unknown opcode, or the end of slot 7.
- WaitTx→Shift happens once transmit data is present.
- WaitRx→Shift happens once the receive register is empty.
- Shift→Decode (or Shift→Idle after slot 7) happens when the last bit completes.
- A soft reset from any state returns to Idle.

Top module: `seqspi_master`

## Requirements
- R1: After reset the status reads exactly 0x0001_0000_0000_0000 (state code 0x01, all flags clear), every chip select is high and SCK is low.
- R2: A program write while idle starts execution at the opcode in bits 63:56, then bits 55:48, and so on downward. A program write while the sequencer is busy is ignored, and the program register keeps its old value.
- R3: Opcode 0x1n drives chip select n-1 low (active low) for n = 1..NUM_CS. 0x10 releases all of them. At most one chip select is ever low.
- R4: Opcode 0x3n sends n bytes of the transmit register in mode 0, MSB first, starting at bits 63:56 and moving downward. MOSI is stable at each SCK rising edge.
- R5: Opcode 0x4n receives n bytes into the receive register right-aligned, with the first byte received in the most significant of the n occupied bytes. MISO is sampled at SCK rising edges.
- R6: Status bit 59 (transmit full) is set by a host write to address 3 and cleared when a shift-out takes the data. While it is clear, a pending shift-out waits in state code 0x04 with SCK low.
- R7: Status bit 63 (receive full) is set when a shift-in completes and cleared by a host read of address 4. While it is set, a pending shift-in waits in state code 0x08 with SCK low.
- R8: Opcode 0xEn jumps to slot n[2:0] and decrements the loop count when the count is nonzero. Otherwise it falls through to the next slot.
- R9: Each SCK high and low phase lasts divider+1 system clocks, where the divider is bits 63:52 of address 2.
- R10: A write to address 2 with bits 39:36 = 0101, immediately followed by a write with bits 39:36 = 1010, returns the sequencer to idle and clears both full flags and all error flags. A 1010 write that is not armed by a preceding 0101 write has no effect. Writes with nonzero bits 39:36 leave the divider unchanged.
- R11: Status bits 55:48 give the state code: Idle 0x01, Decode 0x02, WaitTx 0x04, WaitRx 0x08, Shift 0x10. Opcode 0x00, unknown opcodes, zero-length shifts and the end of slot 7 all return to Idle with every chip select released.
- R12: The following sticky flags stay set until a soft reset:
  - bit 58: transmit write while full; the data is dropped and the old data kept.
  - bit 57: program started with transmit data unconsumed.
  - bit 62: program started with receive data unread.
  - bit 61: receive read while empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effect on address 4) |
| host_addr | input | 3 | Register address |
| host_wdata | input | 64 | Write data |
| host_rdata | output | 64 | Read data for host_addr |
| sck | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low device selects |

## Verification
Several program shapes are run:
- A plain select/send/deselect program, which shows byte order and chip-select choice.
- A counted loop, which shows the branch target and the decrement by the exact number of repetitions.
- The same loop with a zero count, which must fall straight through.
- A receive program, which shows right alignment.
- Back-to-back receives with the first byte left unread, which separates a true stall from running on and overwriting.

Out-of-order host accesses are used to raise each error flag. These include a double transmit write, a program started over leftover data and a read of an empty receive register. An unarmed and an armed reset sequence are then applied. A second divider value confirms that the SCK phase length tracks the register.

// File: rtl/seqspi_pkg.sv
package seqspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_WAIT_TX,
        ST_WAIT_RX,
        ST_SHIFT
    } seq_state_e;

    localparam logic [2:0] A_PROG = 3'd0;
    localparam logic [2:0] A_LOOP = 3'd1;
    localparam logic [2:0] A_CLK  = 3'd2;
    localparam logic [2:0] A_TX   = 3'd3;
    localparam logic [2:0] A_RX   = 3'd4;
    localparam logic [2:0] A_STAT = 3'd5;

    localparam logic [3:0] OPC_STOP = 4'h0;
    localparam logic [3:0] OPC_SEL  = 4'h1;
    localparam logic [3:0] OPC_OUT  = 4'h3;
    localparam logic [3:0] OPC_IN   = 4'h4;
    localparam logic [3:0] OPC_BR   = 4'hE;

    localparam logic [3:0] RST_STEP1 = 4'b0101;
    localparam logic [3:0] RST_STEP2 = 4'b1010;

    function automatic logic [7:0] state_code(seq_state_e s);
        logic [7:0] c;
        unique case (s)
            ST_IDLE:    c = 8'h01;
            ST_DECODE:  c = 8'h02;
            ST_WAIT_TX: c = 8'h04;
            ST_WAIT_RX: c = 8'h08;
            ST_SHIFT:   c = 8'h10;
            default:    c = 8'h00;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/seqspi_baud.sv
module seqspi_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (!en || tick)   cnt <= '0;
        else                    cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/seqspi_shifter.sv
module seqspi_shifter #(
    parameter int W    = 64,
    parameter int NB_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            start,
    input  logic            dir_out,
    input  logic [NB_W-1:0] nbytes,
    input  logic [W-1:0]    tx_word,
    input  logic            tick,
    input  logic            miso,
    output logic            busy,
    output logic            done,
    output logic [W-1:0]    rx_word,
    output logic            sck,
    output logic            mosi
);
    localparam int BITS_W = NB_W + 3;

    logic              active;
    logic              phase;
    logic              out_mode;
    logic [BITS_W-1:0] bits_left;
    logic [W-1:0]      sh_out;
    logic [W-1:0]      sh_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            phase     <= 1'b0;
            out_mode  <= 1'b0;
            bits_left <= '0;
            sh_out    <= '0;
            sh_in     <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                active <= 1'b0;
                phase  <= 1'b0;
            end else if (start && !active) begin
                sh_out    <= tx_word;
                sh_in     <= '0;
                bits_left <= {nbytes, 3'b000};
                out_mode  <= dir_out;
                phase     <= 1'b0;
                active    <= 1'b1;
            end else if (active && tick) begin
                if (!phase) begin
                    phase <= 1'b1;
                    sh_in <= {sh_in[W-2:0], miso};
                end else begin
                    phase     <= 1'b0;
                    sh_out    <= {sh_out[W-2:0], 1'b0};
                    bits_left <= bits_left - BITS_W'(1);
                    if (bits_left == BITS_W'(1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end

    assign busy    = active;
    assign rx_word = sh_in;
    assign sck     = active && phase;
    assign mosi    = active && out_mode && sh_out[W-1];
endmodule

// File: rtl/seqspi_ctrl.sv
module seqspi_ctrl
    import seqspi_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int W      = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              go,
    input  logic [W-1:0]      prog,
    input  logic [7:0]        loop_cnt,
    input  logic              tx_full,
    input  logic              rx_full,
    input  logic              shift_done,
    output logic              shift_start,
    output logic              shift_dir_out,
    output logic [3:0]        shift_nbytes,
    output logic              tx_take,
    output logic              rx_load,
    output logic              loop_dec,
    output logic [NUM_CS-1:0] cs_n,
    output seq_state_e        state
);
    localparam int SLOTS = W / 8;
    localparam int PC_W  = $clog2(SLOTS);

    seq_state_e      nstate;
    logic [PC_W-1:0] pc, npc;
    logic [3:0]      dev_sel, nsel;
    logic [3:0]      nb_q, nnb;
    logic            in_mode, nmode;
    logic [7:0]      op;
    logic            last;
    seq_state_e      adv_state;
    logic [PC_W-1:0] adv_pc;

    assign op        = prog[8*(SLOTS-1-int'(pc)) +: 8];
    assign last      = (pc == PC_W'(SLOTS-1));
    assign adv_state = last ? ST_IDLE : ST_DECODE;
    assign adv_pc    = last ? pc : pc + PC_W'(1);

    always_comb begin
        nstate      = state;
        npc         = pc;
        nsel        = dev_sel;
        nnb         = nb_q;
        nmode       = in_mode;
        shift_start = 1'b0;
        tx_take     = 1'b0;
        rx_load     = 1'b0;
        loop_dec    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    nstate = ST_DECODE;
                    npc    = '0;
                end
            end
            ST_DECODE: begin
                case (op[7:4])
                    OPC_SEL: begin
                        nstate = adv_state;
                        npc    = adv_pc;
                        nsel   = last ? 4'd0 : op[3:0];
                    end
                    OPC_OUT, OPC_IN: begin
                        if (op[3:0] == 4'd0) begin
                            nstate = ST_IDLE;
                            nsel   = 4'd0;
                        end else begin
                            nstate = (op[7:4] == OPC_OUT) ? ST_WAIT_TX : ST_WAIT_RX;
                            nnb    = op[3:0];
                            nmode  = (op[7:4] == OPC_IN);
                        end
                    end
                    OPC_BR: begin
                        if (loop_cnt != 8'd0) begin
                            loop_dec = 1'b1;
                            npc      = op[PC_W-1:0];
                        end else begin
                            nstate = adv_state;
                            npc    = adv_pc;
                            if (last) nsel = 4'd0;
                        end
                    end
                    default: begin
                        nstate = ST_IDLE;
                        nsel   = 4'd0;
                    end
                endcase
            end
            ST_WAIT_TX: begin
                if (tx_full) begin
                    shift_start = 1'b1;
                    tx_take     = 1'b1;
                    nstate      = ST_SHIFT;
                end
            end
            ST_WAIT_RX: begin
                if (!rx_full) begin
                    shift_start = 1'b1;
                    nstate      = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (shift_done) begin
                    rx_load = in_mode;
                    nstate  = adv_state;
                    npc     = adv_pc;
                    if (last) nsel = 4'd0;
                end
            end
            default: begin
                nstate = ST_IDLE;
                nsel   = 4'd0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pc      <= '0;
            dev_sel <= 4'd0;
            nb_q    <= 4'd0;
            in_mode <= 1'b0;
        end else if (sw_rst) begin
            state   <= ST_IDLE;
            pc      <= '0;
            dev_sel <= 4'd0;
        end else begin
            state   <= nstate;
            pc      <= npc;
            dev_sel <= nsel;
            nb_q    <= nnb;
            in_mode <= nmode;
        end
    end

    assign shift_dir_out = !in_mode;
    assign shift_nbytes  = nb_q;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = (dev_sel != 4'(i + 1));
    end
endmodule

// File: rtl/seqspi_master.sv
module seqspi_master
    import seqspi_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2:0]        host_addr,
    input  logic [63:0]       host_wdata,
    output logic [63:0]       host_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);
    localparam int W       = 64;
    localparam int DIV_LSB = 52;

    seq_state_e       seq_state;
    logic [7:0]       stat_state;
    logic [W-1:0]     prog_q, tx_q, rx_q, rx_word;
    logic [7:0]       loop_q;
    logic [DIV_W-1:0] div_q;
    logic             tx_full, rx_full, rst_armed;
    logic             f_tx_left, f_tx_ovw, f_rx_empty, f_rx_unread;
    logic             sw_rst, go, rx_rd, wr_tx, wr_clk;
    logic             shift_start, shift_dir_out, shift_done, shift_busy, tick;
    logic [3:0]       shift_nbytes;
    logic             tx_take, rx_load, loop_dec;
    logic [3:0]       rst_field;

    assign stat_state = state_code(seq_state);
    assign rst_field  = host_wdata[39:36];
    assign wr_clk     = host_wr && (host_addr == A_CLK);
    assign wr_tx      = host_wr && (host_addr == A_TX);
    assign sw_rst     = wr_clk && rst_armed && (rst_field == RST_STEP2);
    assign go         = host_wr && (host_addr == A_PROG) && (seq_state == ST_IDLE);
    assign rx_rd      = host_rd && (host_addr == A_RX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q    <= '0;
            loop_q    <= 8'd0;
            div_q     <= '0;
            rst_armed <= 1'b0;
        end else begin
            if (go) prog_q <= host_wdata;
            if (loop_dec)
                loop_q <= loop_q - 8'd1;
            else if (host_wr && host_addr == A_LOOP)
                loop_q <= host_wdata[39:32];
            if (wr_clk) begin
                if (rst_field == 4'd0) div_q <= host_wdata[DIV_LSB +: DIV_W];
                rst_armed <= (rst_field == RST_STEP1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;  tx_full <= 1'b0;
            rx_q <= '0;  rx_full <= 1'b0;
            f_tx_left <= 1'b0;  f_tx_ovw <= 1'b0;
            f_rx_empty <= 1'b0; f_rx_unread <= 1'b0;
        end else if (sw_rst) begin
            tx_full <= 1'b0;  rx_full <= 1'b0;
            f_tx_left <= 1'b0;  f_tx_ovw <= 1'b0;
            f_rx_empty <= 1'b0; f_rx_unread <= 1'b0;
        end else begin
            if (go && tx_full) f_tx_left   <= 1'b1;
            if (go && rx_full) f_rx_unread <= 1'b1;
            if (tx_take) tx_full <= 1'b0;
            if (wr_tx) begin
                if (tx_full) f_tx_ovw <= 1'b1;
                else begin
                    tx_q    <= host_wdata;
                    tx_full <= 1'b1;
                end
            end
            if (rx_rd) begin
                if (rx_full) rx_full <= 1'b0;
                else         f_rx_empty <= 1'b1;
            end
            if (rx_load) begin
                rx_q    <= rx_word;
                rx_full <= 1'b1;
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_PROG: host_rdata = prog_q;
            A_LOOP: host_rdata[39:32] = loop_q;
            A_CLK:  host_rdata[DIV_LSB +: DIV_W] = div_q;
            A_TX:   host_rdata = tx_q;
            A_RX:   host_rdata = rx_q;
            A_STAT: host_rdata = {rx_full, f_rx_unread, f_rx_empty, 1'b0,
                                  tx_full, f_tx_ovw, f_tx_left, 1'b0,
                                  stat_state, 48'd0};
            default: host_rdata = '0;
        endcase
    end

    seqspi_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .en(shift_busy), .div(div_q), .tick(tick)
    );

    seqspi_shifter #(.W(W), .NB_W(4)) u_shift (
        .clk(clk), .rst_n(rst_n), .abort(sw_rst), .start(shift_start),
        .dir_out(shift_dir_out), .nbytes(shift_nbytes), .tx_word(tx_q),
        .tick(tick), .miso(miso), .busy(shift_busy), .done(shift_done),
        .rx_word(rx_word), .sck(sck), .mosi(mosi)
    );

    seqspi_ctrl #(.NUM_CS(NUM_CS), .W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .go(go), .prog(prog_q),
        .loop_cnt(loop_q), .tx_full(tx_full), .rx_full(rx_full),
        .shift_done(shift_done), .shift_start(shift_start),
        .shift_dir_out(shift_dir_out), .shift_nbytes(shift_nbytes),
        .tx_take(tx_take), .rx_load(rx_load), .loop_dec(loop_dec),
        .cs_n(cs_n), .state(seq_state)
    );
endmodule

// File: rtl/seqspi_master_chk.sv
module seqspi_master_chk #(
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic [NUM_CS-1:0] cs_n,
    input logic [7:0]        state_code,
    input logic              tx_full,
    input logic              rx_full,
    input logic              rx_rd,
    input logic              sw_rst,
    input logic [DIV_W-1:0]  div
);
    logic [DIV_W:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hi_cnt <= '0;
        else if (sck) hi_cnt <= hi_cnt + (DIV_W+1)'(1);
        else          hi_cnt <= '0;
    end

    // R3
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R6
    tx_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 8'h04) |-> !sck);

    // R7
    rx_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 8'h08) |-> !sck);

    // R7
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(rx_rd || sw_rst));

    // R9
    sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sck) && !$past(sw_rst)) |-> (hi_cnt == ({1'b0, div} + (DIV_W+1)'(1))));

    // R10
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (state_code == 8'h01 && !tx_full && !rx_full && !sck));

    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 8'h01) |-> (&cs_n && !sck));
endmodule

bind seqspi_master seqspi_master_chk #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .state_code(stat_state),
    .tx_full(tx_full), .rx_full(rx_full), .rx_rd(rx_rd), .sw_rst(sw_rst),
    .div(div_q)
);

// File: tb/seqspi_master_test.sv
module seqspi_master_test;
    localparam int NCS = 4;
    localparam logic [2:0] A_PROG = 0, A_LOOP = 1, A_CLK = 2, A_TX = 3, A_RX = 4, A_STAT = 5;
    localparam logic [63:0] IDLE_STAT = 64'h0001_0000_0000_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [63:0] host_wdata = '0, host_rdata;
    logic sck, mosi, miso;
    logic [NCS-1:0] cs_n;

    int n_checks = 0, n_fails = 0;
    logic [7:0] exp_q[$];
    logic [NCS-1:0] exp_cs = '1;
    bit mon_on = 1'b0;
    logic [7:0] acc = '0;
    int mbits = 0;
    logic [63:0] slv_word = '0;
    int slv_idx = 0;
    logic [63:0] r;

    always #2.5 clk = ~clk;

    seqspi_master #(.NUM_CS(NCS), .DIV_W(12)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    assign miso = (slv_idx < 64) ? slv_word[63 - slv_idx] : 1'b0;
    always @(negedge sck) slv_idx = slv_idx + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected MOSI bytes
    always @(posedge sck) begin
        if (mon_on) begin
            acc = {acc[6:0], mosi};
            mbits++;
            if (mbits == 8) begin
                mbits = 0;
                if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", {56'd0, acc}, 64'd0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(acc == e, "R4 mosi byte", {56'd0, acc}, {56'd0, e});
                end
                chk(cs_n == exp_cs, "R3 chip select", {60'd0, cs_n}, {60'd0, exp_cs});
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic push_tx(input logic [63:0] w, input int nb);
        for (int i = 0; i < nb; i++) exp_q.push_back(w[63 - 8*i -: 8]);
        wr(A_TX, w);
    endtask

    task automatic wait_bit(input int b, input logic v, input string req);
        logic [63:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(A_STAT, s);
            if (s[b] == v) return;
        end
        chk(1'b0, req, s, 64'(v) << b);
    endtask

    task automatic wait_idle(input string req);
        logic [63:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(A_STAT, s);
            if (s[55:48] == 8'h01) return;
        end
        chk(1'b0, req, {56'd0, s[55:48]}, 64'h01);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_STAT, r);
        chk(r == IDLE_STAT, "R1 status", r, IDLE_STAT);
        chk(cs_n == '1 && sck == 1'b0, "R1 pins", {59'd0, sck, cs_n}, 64'h0F);

        // R2 R4 R6 plain send, divider 1
        wr(A_CLK, 64'd1 << 52);
        mon_on = 1'b1; exp_cs = 4'b1110;
        wr(A_PROG, 64'h1133_1000_0000_0000);
        repeat (6) @(posedge clk);
        rd(A_STAT, r);
        chk(r[55:48] == 8'h04 && !sck, "R6 wait for tx", {56'd0, r[55:48]}, 64'h04);
        push_tx(64'hA1B2_C3D4_E5F6_0718, 3);
        wait_idle("R2 program end");
        chk(exp_q.size() == 0, "R4 all bytes sent", 64'(exp_q.size()), 64'd0);
        rd(A_STAT, r);
        chk(r[59] == 1'b0, "R6 tx consumed", {63'd0, r[59]}, 64'd0);
        chk(cs_n == '1, "R11 released at stop", {60'd0, cs_n}, 64'hF);

        // R8 loop of three iterations
        wr(A_LOOP, 64'd2 << 32);
        wr(A_PROG, 64'h1132_E110_0000_0000);
        push_tx(64'h1122_0000_0000_0000, 2);
        wait_bit(59, 1'b0, "R6 take 1");
        push_tx(64'h3344_0000_0000_0000, 2);
        wait_bit(59, 1'b0, "R6 take 2");
        push_tx(64'h5566_0000_0000_0000, 2);
        wait_idle("R8 loop end");
        chk(exp_q.size() == 0, "R8 three passes", 64'(exp_q.size()), 64'd0);
        rd(A_LOOP, r);
        chk(r == 64'd0, "R8 count decremented", r, 64'd0);

        // R8 zero count falls through
        wr(A_PROG, 64'h1131_E110_0000_0000);
        push_tx(64'hC500_0000_0000_0000, 1);
        wait_idle("R8 fall through");
        chk(exp_q.size() == 0, "R8 one pass", 64'(exp_q.size()), 64'd0);

        // R5 R7 receive three bytes
        mon_on = 1'b0;
        slv_word = 64'h5A3C_7E00_0000_0000; slv_idx = 0;
        wr(A_PROG, 64'h1243_1000_0000_0000);
        wait_bit(63, 1'b1, "R7 rx full set");
        rd(A_RX, r);
        chk(r == 64'h5A3C7E, "R5 right aligned", r, 64'h5A3C7E);
        rd(A_STAT, r);
        chk(r[63] == 1'b0, "R7 cleared by read", {63'd0, r[63]}, 64'd0);
        wait_idle("R5 end");

        // R7 stall while full, R2 busy write ignored
        slv_idx = 0;
        wr(A_PROG, 64'h1241_4110_0000_0000);
        wait_bit(63, 1'b1, "R7 first byte");
        repeat (40) @(posedge clk);
        rd(A_STAT, r);
        chk(r[55:48] == 8'h08 && !sck, "R7 wait for space", {56'd0, r[55:48]}, 64'h08);
        wr(A_PROG, 64'h0);
        rd(A_PROG, r);
        chk(r == 64'h1241_4110_0000_0000, "R2 busy write ignored", r, 64'h1241_4110_0000_0000);
        rd(A_RX, r);
        chk(r == 64'h5A, "R5 first byte", r, 64'h5A);
        wait_idle("R7 resume");
        wr(A_PROG, 64'h1000_0000_0000_0000);
        rd(A_STAT, r);
        chk(r[62] == 1'b1, "R12 rx unread flag", {63'd0, r[62]}, 64'd1);
        rd(A_RX, r);
        chk(r == 64'h3C, "R5 second byte", r, 64'h3C);
        rd(A_RX, r);
        rd(A_STAT, r);
        chk(r[61] == 1'b1, "R12 rx empty read flag", {63'd0, r[61]}, 64'd1);

        // R6 R12 transmit flags
        wr(A_TX, 64'hDEAD_0000_0000_0001);
        rd(A_STAT, r);
        chk(r[59] == 1'b1, "R6 tx full set", {63'd0, r[59]}, 64'd1);
        wr(A_TX, 64'hBEEF_0000_0000_0002);
        rd(A_TX, r);
        chk(r == 64'hDEAD_0000_0000_0001, "R12 overwrite dropped", r, 64'hDEAD_0000_0000_0001);
        wr(A_PROG, 64'h1000_0000_0000_0000);
        wait_idle("R11 short program");
        rd(A_STAT, r);
        chk(r[58] && r[57], "R12 tx flags", {62'd0, r[58], r[57]}, 64'd3);

        // R10 unarmed then armed reset
        wr(A_CLK, 64'h0000_00A0_0000_0000);
        rd(A_STAT, r);
        chk(r[57] == 1'b1, "R10 unarmed no effect", {63'd0, r[57]}, 64'd1);
        wr(A_CLK, 64'h0000_0050_0000_0000);
        wr(A_CLK, 64'h0000_00A0_0000_0000);
        rd(A_STAT, r);
        chk(r == IDLE_STAT, "R10 reset clears", r, IDLE_STAT);
        rd(A_CLK, r);
        chk(r == 64'd1 << 52, "R10 divider kept", r, 64'd1 << 52);

        // R9 divider 3: high phase of 4 clocks
        wr(A_CLK, 64'd3 << 52);
        mon_on = 1'b1; mbits = 0; exp_cs = 4'b1110;
        wr(A_PROG, 64'h1131_1000_0000_0000);
        push_tx(64'h9600_0000_0000_0000, 1);
        begin
            int n;
            n = 0;
            @(posedge sck);
            while (sck) begin
                @(posedge clk); #1;
                n++;
            end
            chk(n == 4, "R9 sck high phase", 64'(n), 64'd4);
        end
        wait_idle("R9 end");
        chk(exp_q.size() == 0, "R4 divided byte", 64'(exp_q.size()), 64'd0);

        finish_up();
    end
endmodule